// File: doc/BRIEF.md
# Serial Hit-Register Control Link

This block is a serial control slave for a multi-channel front-end. A host drives an enable line, a serial clock and a data line, and reads a data-out line. Two wide registers can be reached through it. The hit register holds one flag per signal channel. Each flag latches from a single-cycle pulse on that channel and stays set until a clear input fires. The selection register is a channel mask that names which channels a later memory readout should visit. Software reads the hit register after a trigger, writes a selection mask, then pulses the clear input before the next acquisition.

A frame starts when enable rises. The first bit is ignored. The second bit is the direction: 1 reads and 0 writes. A 5-bit address follows. A write then carries one full register's worth of data. A read spends one serial period turning the line around and then shifts the addressed register out, one bit per serial period. The serial lines are oversampled in the system clock domain. The block also drives a combined trigger output that is high whenever any hit flag is set.

Top module: `slow_ctl_link`

## Requirements
- R1: Bit 0 of a frame is ignored. Bit 1 selects the direction (1 = read, 0 = write). Bits 2 to 6 carry the 5-bit address, most significant bit first. Bits are taken on rising edges of `sc_clk` while `sc_en` is high.
- R2: A one-cycle high on `hit_pulse[i]` sets hit flag i, and the flag stays set until a clear.
- R3: `hit_clr` empties all hit flags. A pulse that arrives in the same cycle as the clear still leaves its own flag set.
- R4: `trig` is high exactly when at least one hit flag is set. It rises in the cycle after the setting pulse.
- R5: A read of address 2 returns all 72 hit flags, highest channel (71) first, one bit per serial period. The first bit appears on the falling edge after the 8th rising edge, so the host samples it at the 9th rising edge.
- R6: A write to address 5 takes 72 data bits on rising edges 8 to 79, most significant first. It loads them into `sel_mask` after the 79th rising edge.
- R7: A read of address 5 returns the current `sel_mask` with the same timing as R5.
- R8: A write to any address other than 5 leaves `sel_mask` unchanged. A read of any address other than 2 or 5 returns all zeros.
- R9: Lowering `sc_en` before a write frame completes discards the frame without changing `sel_mask`. The next frame starts from bit 0.
- R10: Read data is captured at the 8th rising edge. Hits that arrive while the bits are shifting out do not appear in that frame, but they are still latched.
- R11: `sc_dout` is 0 while idle, during the header and turnaround bits, and after the last data bit of a read.
- R12: After reset, all hit flags, `sel_mask`, `trig` and `sc_dout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are oversampled on it |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_en | input | 1 | Frame enable; high for the length of a frame |
| sc_clk | input | 1 | Serial clock from the host |
| sc_din | input | 1 | Serial data from the host |
| sc_dout | output | 1 | Serial read data to the host |
| hit_pulse | input | NCH (72) | Per-channel hit pulses, synchronous to `clk` |
| hit_clr | input | 1 | Clears all hit flags |
| sel_mask | output | NCH (72) | Readout channel selection mask |
| trig | output | 1 | OR of all hit flags |

## Verification
The bench builds the block with its default parameters: 72 channels, a 5-bit address, two synchronizer stages and a combinational trigger. With a 5-bit address all 32 addresses can be swept for both reads and writes, so every unknown address is exercised for both directions. Groups of channels spaced 12 apart cover every bit position of the readout in twelve frames. A walking single pulse across all 72 channels checks the trigger one channel at a time. A 12-clock serial period leaves enough slack to sample data-out on a single clock cycle after the synchronizer latency.

// File: rtl/slow_ctl_pkg.sv
package slow_ctl_pkg;

   // Serial line bundle carried through the synchronizer
   typedef struct packed {
      logic sclk;
      logic en;
      logic din;
   } sc_lines_t;

   // Frame position counted in rising serial edges
   function automatic int unsigned data_first_edge(input int unsigned aw);
      return aw + 2;
   endfunction

   function automatic int unsigned data_last_edge(input int unsigned aw, input int unsigned nch);
      return aw + 1 + nch;
   endfunction

endpackage

// File: rtl/sc_sync_edge.sv
module sc_sync_edge
   import slow_ctl_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sc_clk,
   input  logic sc_en,
   input  logic sc_din,
   output logic en_s,
   output logic din_s,
   output logic rise,
   output logic fall
);

   sc_lines_t chain [STAGES];
   logic      sclk_prev;

   genvar g;
   generate
      for (g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= '{sclk: sc_clk, en: sc_en, din: sc_din};
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) chain[g] <= '0;
               else        chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= chain[STAGES-1].sclk;
   end

   assign en_s  = chain[STAGES-1].en;
   assign din_s = chain[STAGES-1].din;
   assign rise  = chain[STAGES-1].sclk & ~sclk_prev;
   assign fall  = ~chain[STAGES-1].sclk & sclk_prev;

endmodule

// File: rtl/hit_flag_bank.sv
module hit_flag_bank #(
   parameter int unsigned NCH      = 72,
   parameter bit          TRIG_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hit_pulse,
   input  logic           hit_clr,
   output logic [NCH-1:0] hit_q,
   output logic           trig
);

   genvar c;
   generate
      for (c = 0; c < NCH; c++) begin : g_flag
         // pulse wins over a clear in the same cycle so no hit is lost
         always_ff @(posedge clk) begin
            if (!rst_n)            hit_q[c] <= 1'b0;
            else if (hit_pulse[c]) hit_q[c] <= 1'b1;
            else if (hit_clr)      hit_q[c] <= 1'b0;
         end
      end

      if (TRIG_REG) begin : g_trig_reg
         logic trig_q;
         always_ff @(posedge clk) begin
            if (!rst_n) trig_q <= 1'b0;
            else        trig_q <= |hit_q;
         end
         assign trig = trig_q;
      end else begin : g_trig_comb
         assign trig = |hit_q;
      end
   endgenerate

endmodule

// File: rtl/sc_frame_ctl.sv
module sc_frame_ctl
   import slow_ctl_pkg::*;
#(
   parameter int unsigned NCH      = 72,
   parameter int unsigned AW       = 5,
   parameter int unsigned ADDR_HIT = 2,
   parameter int unsigned ADDR_SEL = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           en_s,
   input  logic           din_s,
   input  logic           rise,
   input  logic           fall,
   input  logic [NCH-1:0] hit_q,
   input  logic [NCH-1:0] sel_q,
   output logic           sc_dout,
   output logic           sel_load,
   output logic [NCH-1:0] sel_wdata,
   output logic           rw
);

   localparam int unsigned D_FIRST = data_first_edge(AW);
   localparam int unsigned D_LAST  = data_last_edge(AW, NCH);
   localparam int unsigned CW      = $clog2(D_LAST + 2);
   localparam int unsigned OW      = $clog2(NCH + 1);

   localparam logic [CW-1:0] E_RW    = CW'(1);
   localparam logic [CW-1:0] E_A0    = CW'(2);
   localparam logic [CW-1:0] E_AL    = CW'(AW + 1);
   localparam logic [CW-1:0] E_DF    = CW'(D_FIRST);
   localparam logic [CW-1:0] E_DL    = CW'(D_LAST);
   localparam logic [CW-1:0] E_SAT   = CW'(D_LAST + 1);
   localparam logic [OW-1:0] O_FULL  = OW'(NCH);
   localparam logic [AW-1:0] A_HIT   = AW'(ADDR_HIT);
   localparam logic [AW-1:0] A_SEL   = AW'(ADDR_SEL);

   logic [CW-1:0]  edge_cnt;
   logic [OW-1:0]  out_cnt;
   logic [AW-1:0]  addr_q;
   logic [NCH-1:0] shreg;
   logic [NCH-1:0] rd_src;
   logic           rw_q;
   logic           rd_act;
   logic           dout_q;
   logic           load_q;

   always_comb begin
      if (addr_q == A_HIT)      rd_src = hit_q;
      else if (addr_q == A_SEL) rd_src = sel_q;
      else                      rd_src = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         edge_cnt <= '0;
         out_cnt  <= '0;
         addr_q   <= '0;
         shreg    <= '0;
         rw_q     <= 1'b0;
         rd_act   <= 1'b0;
         dout_q   <= 1'b0;
         load_q   <= 1'b0;
      end else begin
         load_q <= 1'b0;
         if (!en_s) begin
            edge_cnt <= '0;
            out_cnt  <= '0;
            rd_act   <= 1'b0;
            dout_q   <= 1'b0;
         end else if (rise) begin
            if (edge_cnt != E_SAT) edge_cnt <= edge_cnt + 1'b1;
            if (edge_cnt == E_RW) begin
               rw_q <= din_s;
            end else if (edge_cnt >= E_A0 && edge_cnt <= E_AL) begin
               addr_q <= {addr_q[AW-2:0], din_s};
            end else if (edge_cnt == E_DF && rw_q) begin
               shreg   <= rd_src;
               rd_act  <= 1'b1;
               out_cnt <= '0;
            end else if (edge_cnt >= E_DF && edge_cnt <= E_DL && !rw_q) begin
               shreg <= {shreg[NCH-2:0], din_s};
               if (edge_cnt == E_DL && addr_q == A_SEL) load_q <= 1'b1;
            end
         end else if (fall) begin
            if (rd_act && out_cnt != O_FULL) begin
               dout_q  <= shreg[NCH-1];
               shreg   <= {shreg[NCH-2:0], 1'b0};
               out_cnt <= out_cnt + 1'b1;
            end else begin
               dout_q <= 1'b0;
            end
         end
      end
   end

   assign sc_dout   = dout_q;
   assign sel_load  = load_q;
   assign sel_wdata = shreg;
   assign rw        = rw_q;

endmodule

// File: rtl/slow_ctl_link.sv
module slow_ctl_link
   import slow_ctl_pkg::*;
#(
   parameter int unsigned NCH         = 72,
   parameter int unsigned AW          = 5,
   parameter int unsigned ADDR_HIT    = 2,
   parameter int unsigned ADDR_SEL    = 5,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TRIG_REG    = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           sc_en,
   input  logic           sc_clk,
   input  logic           sc_din,
   output logic           sc_dout,
   input  logic [NCH-1:0] hit_pulse,
   input  logic           hit_clr,
   output logic [NCH-1:0] sel_mask,
   output logic           trig
);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("slow_ctl_link: NCH must be at least 2");
      end
      if (AW < 2) begin : g_bad_aw
         $error("slow_ctl_link: AW must be at least 2");
      end
      if (ADDR_HIT == ADDR_SEL) begin : g_bad_addr
         $error("slow_ctl_link: register addresses must differ");
      end
      if (ADDR_HIT >= (1 << AW) || ADDR_SEL >= (1 << AW)) begin : g_bad_range
         $error("slow_ctl_link: address does not fit AW");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("slow_ctl_link: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic           en_s;
   logic           din_s;
   logic           sc_rise;
   logic           sc_fall;
   logic [NCH-1:0] hit_q;
   logic [NCH-1:0] sel_q;
   logic [NCH-1:0] sel_wdata;
   logic           sel_load;
   logic           cur_rw;

   sc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .sc_clk(sc_clk),
      .sc_en (sc_en),
      .sc_din(sc_din),
      .en_s  (en_s),
      .din_s (din_s),
      .rise  (sc_rise),
      .fall  (sc_fall)
   );

   hit_flag_bank #(.NCH(NCH), .TRIG_REG(TRIG_REG)) u_hits (
      .clk      (clk),
      .rst_n    (rst_n),
      .hit_pulse(hit_pulse),
      .hit_clr  (hit_clr),
      .hit_q    (hit_q),
      .trig     (trig)
   );

   sc_frame_ctl #(
      .NCH     (NCH),
      .AW      (AW),
      .ADDR_HIT(ADDR_HIT),
      .ADDR_SEL(ADDR_SEL)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_s     (en_s),
      .din_s    (din_s),
      .rise     (sc_rise),
      .fall     (sc_fall),
      .hit_q    (hit_q),
      .sel_q    (sel_q),
      .sc_dout  (sc_dout),
      .sel_load (sel_load),
      .sel_wdata(sel_wdata),
      .rw       (cur_rw)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)        sel_q <= '0;
      else if (sel_load) sel_q <= sel_wdata;
   end

   assign sel_mask = sel_q;

endmodule

// File: rtl/slow_ctl_link_chk.sv
module slow_ctl_link_chk #(
   parameter int unsigned NCH      = 72,
   parameter bit          TRIG_REG = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] hit_pulse,
   input logic           hit_clr,
   input logic [NCH-1:0] hit_q,
   input logic           trig,
   input logic [NCH-1:0] sel_mask,
   input logic           sel_load,
   input logic           rw,
   input logic           en_s,
   input logic           sc_dout
);

   // R2: a set flag survives every cycle without a clear
   p_hit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_clr |=> ((hit_q & $past(hit_q)) == $past(hit_q)));

   // R3: clear with no concurrent pulse empties the bank
   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_clr && hit_pulse == '0) |=> (hit_q == '0));

   // R4: any pulse raises the trigger
   generate
      if (TRIG_REG) begin : g_reg
         p_trig_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_pulse != '0) |=> ##1 trig);
      end else begin : g_comb
         p_trig_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_pulse != '0) |=> trig);
      end
   endgenerate

   // R9: mask moves only on a completed write
   p_sel_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_load |=> $stable(sel_mask));

   // R8: a load never comes from a read frame
   p_load_is_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sel_load |-> !rw);

   // R11: data-out is quiet without an active frame
   p_dout_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en_s |=> !sc_dout);

endmodule

bind slow_ctl_link slow_ctl_link_chk #(.NCH(NCH), .TRIG_REG(TRIG_REG)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .hit_pulse(hit_pulse),
   .hit_clr  (hit_clr),
   .hit_q    (hit_q),
   .trig     (trig),
   .sel_mask (sel_mask),
   .sel_load (sel_load),
   .rw       (cur_rw),
   .en_s     (en_s),
   .sc_dout  (sc_dout)
);

// File: tb/sim_slow_ctl_link.sv
`timescale 1ns/1ps
module sim_slow_ctl_link;

   localparam int N     = 72;
   localparam int HALF  = 6;       // system clocks per serial half period
   localparam int A_HIT = 2;
   localparam int A_SEL = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sc_en = 1'b0;
   logic         sc_clk = 1'b0;
   logic         sc_din = 1'b0;
   logic         sc_dout;
   logic [N-1:0] hit_pulse = '0;
   logic         hit_clr = 1'b0;
   logic [N-1:0] sel_mask;
   logic         trig;

   int nchk  = 0;
   int nfail = 0;
   int cyc   = 0;

   always #10 clk = ~clk;   // 50 MHz

   slow_ctl_link u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .sc_en    (sc_en),
      .sc_clk   (sc_clk),
      .sc_din   (sc_din),
      .sc_dout  (sc_dout),
      .hit_pulse(hit_pulse),
      .hit_clr  (hit_clr),
      .sel_mask (sel_mask),
      .trig     (trig)
   );

   task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // one serial period: fall, settle, sample data-out, rise, settle
   task automatic sc_bit(input logic b, output logic seen);
      sc_clk = 1'b0;
      sc_din = b;
      wait_clk(HALF);
      seen = sc_dout;
      sc_clk = 1'b1;
      wait_clk(HALF);
   endtask

   function automatic logic hdr_bit(input int k, input logic dc, input logic rwb, input int addr);
      if (k == 0) return dc;
      if (k == 1) return rwb;
      if (k <= 6) return 1'(addr >> (6 - k));
      return 1'b0;
   endfunction

   task automatic pulse_hits(input logic [N-1:0] m, input logic clr);
      hit_pulse = m;
      hit_clr   = clr;
      @(negedge clk);
      hit_pulse = '0;
      hit_clr   = 1'b0;
   endtask

   // read frame; optional hit injection at serial period inj_k
   task automatic rd_frame(input int addr, input logic dc, input int inj_k, input logic [N-1:0] inj_m,
                           output logic [N-1:0] data, output bit quiet_ok);
      logic seen;
      data = '0;
      quiet_ok = 1'b1;
      sc_clk = 1'b0;
      sc_en  = 1'b1;
      wait_clk(HALF);
      for (int k = 0; k < 81; k++) begin
         if (k == inj_k) pulse_hits(inj_m, 1'b0);
         sc_bit(hdr_bit(k, dc, 1'b1, addr), seen);
         if (k >= 8 && k < 80) data[79-k] = seen;
         else if (seen !== 1'b0) quiet_ok = 1'b0;
      end
      sc_en  = 1'b0;
      sc_clk = 1'b0;
      wait_clk(10);
   endtask

   // write frame; abort_k < 79 lowers enable early
   task automatic wr_frame(input int addr, input logic dc, input logic [N-1:0] d, input int abort_k);
      logic seen;
      sc_clk = 1'b0;
      sc_en  = 1'b1;
      wait_clk(HALF);
      for (int k = 0; k < 79; k++) begin
         if (k == abort_k) break;
         sc_bit((k < 7) ? hdr_bit(k, dc, 1'b0, addr) : d[78-k], seen);
      end
      sc_en  = 1'b0;
      sc_clk = 1'b0;
      wait_clk(10);
   endtask

   function automatic logic [N-1:0] wpat(input int a);
      return {8'hA5 ^ 8'(a), 32'h1234_5678 + 32'(a), 32'h9ABC_DEF0 ^ {4{8'(a)}}};
   endfunction

   function automatic logic [N-1:0] grp(input int k);
      logic [N-1:0] m = '0;
      for (int c = 0; c < N; c++) if (c % 12 == k) m[c] = 1'b1;
      return m;
   endfunction

   initial begin : watchdog
      while (cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, 190000);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin : stim
      logic [N-1:0] rd;
      logic [N-1:0] exp_sel;
      bit           q;
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);

      // R12 reset state
      chk(sel_mask == '0, "R12 sel after reset", sel_mask, '0);
      chk(trig == 1'b0 && sc_dout == 1'b0, "R12 trig/dout after reset", {trig, sc_dout}, '0);

      // R4 / R3 walking single pulse across every channel
      for (int c = 0; c < N; c++) begin
         pulse_hits(N'(1) << c, 1'b0);
         chk(trig == 1'b1, $sformatf("R4 trig after pulse ch%0d", c), N'(trig), N'(1));
         pulse_hits('0, 1'b1);
         chk(trig == 1'b0, $sformatf("R3 trig after clear ch%0d", c), N'(trig), '0);
      end

      // R5 / R2 / R11 group readback covering every bit position
      for (int k = 0; k < 12; k++) begin
         pulse_hits(grp(k), 1'b0);
         wait_clk(20);
         rd_frame(A_HIT, k[0], -1, '0, rd, q);
         chk(rd == grp(k), $sformatf("R5 hit readback group %0d", k), rd, grp(k));
         chk(q, $sformatf("R11 quiet dout group %0d", k), N'(q), N'(1));
         pulse_hits('0, 1'b1);
      end

      // R5 channel 71 leads: only the top flag set
      pulse_hits({1'b1, {(N-1){1'b0}}}, 1'b0);
      rd_frame(A_HIT, 1'b1, -1, '0, rd, q);
      chk(rd == {1'b1, {(N-1){1'b0}}}, "R5 top channel first", rd, {1'b1, {(N-1){1'b0}}});
      pulse_hits('0, 1'b1);

      // R3 pulse concurrent with clear survives, older flag gone
      pulse_hits(N'(1) << 9, 1'b0);
      pulse_hits(N'(1) << 5, 1'b1);
      rd_frame(A_HIT, 1'b0, -1, '0, rd, q);
      chk(rd == (N'(1) << 5), "R3 same-cycle pulse and clear", rd, N'(1) << 5);
      pulse_hits('0, 1'b1);

      // R10 hit during shift-out is absent now, present next frame
      pulse_hits(N'(1) << 40, 1'b0);
      rd_frame(A_HIT, 1'b0, 30, N'(1) << 3, rd, q);
      chk(rd == (N'(1) << 40), "R10 frozen snapshot", rd, N'(1) << 40);
      rd_frame(A_HIT, 1'b0, -1, '0, rd, q);
      chk(rd == ((N'(1) << 40) | (N'(1) << 3)), "R10 late hit latched", rd, (N'(1) << 40) | (N'(1) << 3));
      pulse_hits('0, 1'b1);

      // R6 / R8 / R1 / R7 write sweep over every address
      exp_sel = '0;
      for (int a = 0; a < 32; a++) begin
         wr_frame(a, a[0], wpat(a), 99);
         if (a == A_SEL) exp_sel = wpat(a);
         chk(sel_mask == exp_sel, $sformatf("R6 R8 R1 sel after write addr %0d", a), sel_mask, exp_sel);
         rd_frame(A_SEL, a[1], -1, '0, rd, q);
         chk(rd == exp_sel, $sformatf("R7 sel readback after addr %0d", a), rd, exp_sel);
      end

      // R9 aborted write leaves mask, next full write works
      wr_frame(A_SEL, 1'b0, ~wpat(3), 40);
      chk(sel_mask == exp_sel, "R9 aborted write ignored", sel_mask, exp_sel);
      wr_frame(A_SEL, 1'b1, ~wpat(3), 99);
      exp_sel = ~wpat(3);
      chk(sel_mask == exp_sel, "R9 write after abort", sel_mask, exp_sel);

      // R8 unknown read addresses return zero with all hits set
      pulse_hits('1, 1'b0);
      for (int a = 0; a < 32; a++) begin
         if (a == A_HIT || a == A_SEL) continue;
         rd_frame(a, a[0], -1, '0, rd, q);
         chk(rd == '0 && q, $sformatf("R8 unknown read addr %0d", a), rd, '0);
      end
      rd_frame(A_HIT, 1'b1, -1, '0, rd, q);
      chk(rd == '1, "R5 R1 all hits, don't-care bit set", rd, '1);
      chk(trig == 1'b1, "R4 trig held", N'(trig), N'(1));
      pulse_hits('0, 1'b1);
      chk(trig == 1'b0 && sc_dout == 1'b0, "R3 R11 idle after clear", {trig, sc_dout}, '0);

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule